// File: doc/BRIEF.md
# Three-Class Interrupt Steering Controller

This block gathers up to 32 level-sensitive request lines from peripherals and steers each of them, under software control, into one of three classes. The fast class has the highest priority and drives a dedicated fast-interrupt line. The vectored class has middle priority and competes for sixteen numbered slots. The non-vectored class has the lowest priority. The vectored and non-vectored classes together drive the normal interrupt line.

Software sets up the block through a small word-addressed register bus. It chooses which sources are live, which of them take the fast path, and which source each slot watches. It also sets the handler address that each slot supplies and one shared fallback address. The interrupt routine reads a vector register to get the handler of the best pending slot, or the fallback when no slot is pending. It then writes that same register to mark the end of service. Between that read and that write the vector stays frozen.

Top module: `vic_top`

## Requirements
- R1: After reset, every configuration register reads zero (all sources disabled, every source in the normal class, all slots disabled with zero addresses, fallback zero), and `fiq_o`, `irq_o` and `vec_addr_o` are low.
- R2: A source whose enable bit (word 0x03, bit n for source n) is clear never reaches `fiq_o`, `irq_o`, the two class status words or the vector logic, whatever its request level.
- R3: `fiq_o` is the OR of all enabled requests whose class bit (word 0x03 enable, word 0x04 class, 1 = fast) is set, registered: it follows the requests one clock edge later.
- R4: Reading word 0x01 returns a bit per source that is requesting, enabled and fast-class.
- R5: `irq_o` is the registered OR of all enabled, requesting, normal-class sources, and reading word 0x02 returns those sources as a bit per source.
- R6: Slot k has a control word at 0x20+k (bit 5 enable, bits 4:0 source number) and a handler word at 0x40+k. Among enabled slots whose source is an enabled, requesting, normal-class source, the lowest slot number wins, and its handler address appears on `vec_addr_o`. A fast-class source never wins a slot.
- R7: A slot whose enable bit is clear takes no part in the arbitration, even when its source is requesting.
- R8: When no slot is pending, `vec_addr_o` and the vector word 0x05 give the fallback address held in word 0x06.
- R9: A read of word 0x05 returns the current vector and freezes it. The vector then stays unchanged, whatever the requests do, until a write to word 0x05. That write recomputes the vector from the requests at that clock edge.
- R10: Reading word 0x00 returns the request lines before any enable or class masking.
- R11: Changes to the class and enable words take effect at run time: the outputs follow the new setting one clock edge after the write edge.
- R12: A read returns its data on `bus_rdata` one clock edge after `bus_rd` is sampled high. `bus_rdata` keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_i | input | NUM_SRC | Level-sensitive request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| fiq_o | output | 1 | Fast interrupt request to the processor |
| irq_o | output | 1 | Normal interrupt request to the processor |
| vec_addr_o | output | DATA_W | Current handler vector |

## Verification
The bench treats `fiq_o`, `irq_o` and the vector as due one clock edge after the requests or the configuration change. Read data is due one edge after the read strobe. A write's effect on the outputs is due one edge after the write edge. The bench changes inputs on falling edges and samples on the falling edge after the edge at which each result becomes due. While the vector is frozen, the bench checks that it does not move over several edges. After the end-of-service write, it checks that the new winner is present at the very next falling edge.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int RA_W = 7;
  localparam logic [RA_W-1:0] A_RAW   = 7'h00;
  localparam logic [RA_W-1:0] A_FIQST = 7'h01;
  localparam logic [RA_W-1:0] A_IRQST = 7'h02;
  localparam logic [RA_W-1:0] A_EN    = 7'h03;
  localparam logic [RA_W-1:0] A_CLS   = 7'h04;
  localparam logic [RA_W-1:0] A_VECT  = 7'h05;
  localparam logic [RA_W-1:0] A_DFLT  = 7'h06;
  localparam logic [RA_W-1:0] A_SCTL  = 7'h20;
  localparam logic [RA_W-1:0] A_SVEC  = 7'h40;

  // Keep only the least significant set bit (lowest slot number wins).
  function automatic logic [31:0] isolate_lowest(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction

  function automatic logic [RA_W-1:0] slot_ctl_addr(input int k);
    return RA_W'(int'(A_SCTL) + k);
  endfunction

  function automatic logic [RA_W-1:0] slot_vec_addr(input int k);
    return RA_W'(int'(A_SVEC) + k);
  endfunction
endpackage

// File: rtl/vic_mask.sv
module vic_mask #(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] raw,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] cls,
  output logic [NUM_SRC-1:0] fiq_st,
  output logic [NUM_SRC-1:0] irq_st
);
  logic [NUM_SRC-1:0] live;

  always_comb begin
    live   = raw & en;
    fiq_st = live & cls;
    irq_st = live & ~cls;
  end
endmodule

// File: rtl/vic_slot_arb.sv
module vic_slot_arb
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32,
  parameter int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]               irq_st,
  input  logic [NUM_SLOT-1:0]              slot_en,
  input  logic [NUM_SLOT-1:0][SRC_W-1:0]   slot_src,
  input  logic [NUM_SLOT-1:0][DATA_W-1:0]  slot_vec,
  input  logic [DATA_W-1:0]                dflt,
  output logic [NUM_SLOT-1:0]              grant,
  output logic                             slot_hit,
  output logic [DATA_W-1:0]                vec_next
);
  logic [NUM_SLOT-1:0] pend;

  generate
    for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
      assign pend[k] = slot_en[k] & irq_st[slot_src[k]];
    end
  endgenerate

  assign grant    = NUM_SLOT'(isolate_lowest(32'(pend)));
  assign slot_hit = |pend;

  always_comb begin
    vec_next = dflt;
    for (int k = 0; k < NUM_SLOT; k++) begin
      if (grant[k]) vec_next = slot_vec[k];
    end
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [RA_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               fiq_o,
  output logic               irq_o,
  output logic [DATA_W-1:0]  vec_addr_o
);
  localparam int SRC_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0]              en_q, cls_q;
  logic [NUM_SLOT-1:0]             slot_en_q;
  logic [NUM_SLOT-1:0][SRC_W-1:0]  slot_src_q;
  logic [NUM_SLOT-1:0][DATA_W-1:0] slot_vec_q;
  logic [DATA_W-1:0]               dflt_q, vec_q, rdata_q, rd_mux;
  logic                            locked_q, fiq_q, irq_q;

  // Named internal events for the checker.
  logic [NUM_SRC-1:0]  fiq_st_w, irq_st_w;
  logic [NUM_SLOT-1:0] grant_w;
  logic                slot_hit_w;
  logic [DATA_W-1:0]   vec_next_w;
  logic                vect_rd_w, eoi_w;

  assign vect_rd_w = bus_rd & (bus_addr == A_VECT);
  assign eoi_w     = bus_wr & (bus_addr == A_VECT);

  vic_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .raw(irq_i), .en(en_q), .cls(cls_q),
    .fiq_st(fiq_st_w), .irq_st(irq_st_w)
  );

  vic_slot_arb #(
    .NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W), .SRC_W(SRC_W)
  ) u_arb (
    .irq_st(irq_st_w), .slot_en(slot_en_q), .slot_src(slot_src_q),
    .slot_vec(slot_vec_q), .dflt(dflt_q),
    .grant(grant_w), .slot_hit(slot_hit_w), .vec_next(vec_next_w)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_RAW:   rd_mux = DATA_W'(irq_i);
      A_FIQST: rd_mux = DATA_W'(fiq_st_w);
      A_IRQST: rd_mux = DATA_W'(irq_st_w);
      A_EN:    rd_mux = DATA_W'(en_q);
      A_CLS:   rd_mux = DATA_W'(cls_q);
      A_VECT:  rd_mux = vec_q;
      A_DFLT:  rd_mux = dflt_q;
      default: ;
    endcase
    for (int k = 0; k < NUM_SLOT; k++) begin
      if (bus_addr == slot_ctl_addr(k)) rd_mux = DATA_W'({slot_en_q[k], slot_src_q[k]});
      if (bus_addr == slot_vec_addr(k)) rd_mux = slot_vec_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= '0;
      cls_q      <= '0;
      slot_en_q  <= '0;
      slot_src_q <= '0;
      slot_vec_q <= '0;
      dflt_q     <= '0;
      vec_q      <= '0;
      rdata_q    <= '0;
      locked_q   <= 1'b0;
      fiq_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_EN:    en_q   <= bus_wdata[NUM_SRC-1:0];
          A_CLS:   cls_q  <= bus_wdata[NUM_SRC-1:0];
          A_DFLT:  dflt_q <= bus_wdata;
          default: ;
        endcase
        for (int k = 0; k < NUM_SLOT; k++) begin
          if (bus_addr == slot_ctl_addr(k)) begin
            slot_en_q[k]  <= bus_wdata[SRC_W];
            slot_src_q[k] <= bus_wdata[SRC_W-1:0];
          end
          if (bus_addr == slot_vec_addr(k)) slot_vec_q[k] <= bus_wdata;
        end
      end
      fiq_q <= |fiq_st_w;
      irq_q <= |irq_st_w;
      if (eoi_w)          locked_q <= 1'b0;
      else if (vect_rd_w) locked_q <= 1'b1;
      if (eoi_w || (!locked_q && !vect_rd_w)) vec_q <= vec_next_w;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign fiq_o      = fiq_q;
  assign irq_o      = irq_q;
  assign vec_addr_o = vec_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fiq_o,
  input logic                irq_o,
  input logic [DATA_W-1:0]   vec_addr_o,
  input logic [NUM_SRC-1:0]  fiq_st,
  input logic [NUM_SRC-1:0]  irq_st,
  input logic [NUM_SRC-1:0]  en,
  input logic [NUM_SLOT-1:0] grant,
  input logic                slot_hit,
  input logic [DATA_W-1:0]   dflt,
  input logic                locked,
  input logic                vect_rd,
  input logic                eoi
);
  p_fiq_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fiq_o == $past(|fiq_st));

  p_irq_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|irq_st));

  p_masked_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> (!fiq_o && !irq_o));

  p_one_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_fallback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_hit && !locked && !vect_rd) |=> vec_addr_o == $past(dflt));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !eoi) |=> $stable(vec_addr_o));

  p_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !locked);
endmodule

bind vic_top vic_chk #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fiq_o(fiq_o), .irq_o(irq_o), .vec_addr_o(vec_addr_o),
  .fiq_st(fiq_st_w), .irq_st(irq_st_w), .en(en_q), .grant(grant_w),
  .slot_hit(slot_hit_w), .dflt(dflt_q), .locked(locked_q),
  .vect_rd(vect_rd_w), .eoi(eoi_w)
);

// File: tb/test_vic_top.sv
module test_vic_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_i;
  logic        bus_wr, bus_rd;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fiq_o, irq_o;
  logic [31:0] vec_addr_o;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  vic_top i_vic_top (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fiq_o(fiq_o), .irq_o(irq_o), .vec_addr_o(vec_addr_o)
  );

  function automatic int src_of(input int k);
    return (k * 5 + 3) % 32;
  endfunction

  function automatic logic [31:0] vec_of(input int k);
    return 32'h0000_1000 + 32'(k * 16);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] d, pat, expv, cls_pat;
    logic [15:0] m;
    rst_n = 1'b0; irq_i = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 fiq_o", 32'(fiq_o), 0);
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 vec", vec_addr_o, 0);
    rd(7'h03, d); check("R1 enable", d, 0);
    rd(7'h04, d); check("R1 class", d, 0);
    rd(7'h06, d); check("R1 fallback", d, 0);
    rd(7'h20, d); check("R1 slot ctl", d, 0);
    rd(7'h4F, d); check("R1 slot vec", d, 0);

    // R10 raw view and R2 masking with all sources disabled
    irq_i = 32'hA5A5_0F0F;
    tick();
    rd(7'h00, d); check("R10 raw", d, 32'hA5A5_0F0F);
    rd(7'h01, d); check("R2 fiq status", d, 0);
    rd(7'h02, d); check("R2 irq status", d, 0);
    check("R2 fiq_o", 32'(fiq_o), 0);
    check("R2 irq_o", 32'(irq_o), 0);
    rd(7'h00, d); check("R12 rdata held", bus_rdata, 32'hA5A5_0F0F);

    // Per-source sweep: one source enabled, class alternating
    irq_i = 32'hFFFF_FFFF;
    for (int s = 0; s < 32; s++) begin
      cls_pat = (s % 2 == 1) ? (32'd1 << s) : 32'd0;
      wr(7'h03, 32'd1 << s);
      wr(7'h04, cls_pat);
      tick();
      check("R3 fiq_o single", 32'(fiq_o), 32'(s % 2 == 1));
      check("R5 irq_o single", 32'(irq_o), 32'(s % 2 == 0));
      rd(7'h01, d); check("R4 fiq status single", d, cls_pat);
      rd(7'h02, d); check("R5 irq status single", d, (32'd1 << s) & ~cls_pat);
    end

    // Mixed patterns with partial enables
    wr(7'h03, 32'h7FFF_FFFE);
    wr(7'h04, 32'h0F0F_00FF);
    for (int i = 0; i < 24; i++) begin
      pat = 32'(i * 32'h9E37_79B9) ^ (32'd1 << i);
      irq_i = pat;
      tick();
      expv = pat & 32'h7FFF_FFFE & 32'h0F0F_00FF;
      check("R3 fiq_o mix", 32'(fiq_o), 32'(expv != 0));
      rd(7'h01, d); check("R4 fiq status mix", d, expv);
      expv = pat & 32'h7FFF_FFFE & ~32'h0F0F_00FF;
      check("R5 irq_o mix", 32'(irq_o), 32'(expv != 0));
      rd(7'h02, d); check("R2 R5 irq status mix", d, expv);
      rd(7'h00, d); check("R10 raw mix", d, pat);
    end

    // R11 run-time reclassification
    wr(7'h03, 32'h0000_0010);
    wr(7'h04, 32'h0);
    irq_i = 32'h0000_0010;
    tick();
    check("R11 before irq", 32'(irq_o), 1);
    wr(7'h04, 32'h0000_0010);
    tick();
    check("R11 after fiq", 32'(fiq_o), 1);
    check("R11 after irq", 32'(irq_o), 0);
    wr(7'h03, 32'h0);
    tick();
    check("R11 disable fiq", 32'(fiq_o), 0);

    // Slot setup
    wr(7'h03, 32'hFFFF_FFFF);
    wr(7'h04, 32'h0);
    wr(7'h06, 32'hDEAD_0000);
    for (int k = 0; k < 16; k++) begin
      wr(7'h20 + 7'(k), 32'h20 | 32'(src_of(k)));
      wr(7'h40 + 7'(k), vec_of(k));
    end
    rd(7'h27, d); check("R6 slot ctl read", d, 32'h20 | 32'(src_of(7)));

    // Slot priority sweep
    for (int i = 0; i < 700; i++) begin
      m = (i == 1) ? 16'hFFFF : 16'((i * 40503) ^ (i << 3));
      pat = '0;
      for (int k = 0; k < 16; k++) if (m[k]) pat |= 32'd1 << src_of(k);
      irq_i = pat;
      tick();
      expv = 32'hDEAD_0000;
      for (int k = 15; k >= 0; k--) if (m[k]) expv = vec_of(k);
      check(m == 0 ? "R8 fallback" : "R6 winner", vec_addr_o, expv);
      check("R5 irq_o slots", 32'(irq_o), 32'(m != 0));
    end

    // R7 disabled slot ignored
    wr(7'h22, 32'(src_of(2)));
    irq_i = (32'd1 << src_of(2)) | (32'd1 << src_of(9));
    tick();
    check("R7 skip disabled", vec_addr_o, vec_of(9));
    irq_i = 32'd1 << src_of(2);
    tick();
    check("R7 R8 only disabled", vec_addr_o, 32'hDEAD_0000);

    // R6 fast-class source never wins a slot
    wr(7'h04, 32'd1 << src_of(0));
    irq_i = (32'd1 << src_of(0)) | (32'd1 << src_of(9));
    tick();
    check("R6 fast excluded", vec_addr_o, vec_of(9));
    check("R3 fast line", 32'(fiq_o), 1);
    wr(7'h04, 32'h0);

    // R2 disabled source never wins a slot
    wr(7'h03, ~(32'd1 << src_of(1)));
    irq_i = (32'd1 << src_of(1)) | (32'd1 << src_of(12));
    tick();
    check("R2 disabled vs slot", vec_addr_o, vec_of(12));
    wr(7'h03, 32'hFFFF_FFFF);

    // R9 freeze on read, release on write
    irq_i = 32'd1 << src_of(5);
    tick();
    rd(7'h05, d); check("R9 read vector", d, vec_of(5));
    irq_i = (32'd1 << src_of(5)) | (32'd1 << src_of(1));
    tick();
    check("R9 held", vec_addr_o, vec_of(5));
    irq_i = '0;
    tick(); tick();
    check("R9 held idle", vec_addr_o, vec_of(5));
    rd(7'h05, d); check("R9 reread held", d, vec_of(5));
    irq_i = 32'd1 << src_of(1);
    tick();
    wr(7'h05, 32'h0);
    check("R9 after end", vec_addr_o, vec_of(1));
    irq_i = '0;
    tick();
    check("R9 unfrozen", vec_addr_o, 32'hDEAD_0000);

    finish_run();
  end
endmodule